// File: doc/BRIEF.md
# Sequential Shift-Subtract Divider

This block divides an unsigned (2N-1)-bit dividend by an N-bit divisor whose most significant bit is set. It takes N clock cycles and produces one quotient bit in each. One row of N+1 subtract-and-select cells is used again on every cycle. The operands sit in a 2N-bit working register. Its upper half carries the running partial remainder. Its lower half is a shift register: the dividend bits leave it from the top, and the quotient bits enter it at the bottom.

A caller presents the operands and pulses `start` while the block is idle. The result is valid on the cycle `done` is high. At that point the quotient sits in the low half of the register and the remainder in the high half. A zero divisor is rejected at once: the block returns an error flag and runs no iterations. Scaling the divisor so its MSB is 1, and correcting the results afterwards, is left to the caller.

Top module: `seq_divider`

## Requirements
- R1: While reset is applied, and after it is released, `busy`, `done` and `div_err` are 0.
- R2: A `start` sampled high while idle with a nonzero divisor captures both operands and sets `busy` from the next cycle.
- R3: An accepted nonzero division lowers `busy` and raises `done` exactly N rising edges after the edge that accepted `start`.
- R4: `done` is high for exactly one cycle per completed operation.
- R5: For a divisor with bit N-1 set, the result seen with `done` satisfies dividend = quotient*divisor + remainder and remainder < divisor.
- R6: A `start` sampled while `busy` is high has no effect: the operation in progress finishes on its normal cycle with its original operands.
- R7: A `start` with divisor 0 does not set `busy`. On the next cycle it raises `done` together with `div_err`.
- R8: `div_err` holds its value until the next accepted `start`, and it is cleared there when that divisor is nonzero.
- R9: Quotient bits arrive MSB first, one per cycle, at the LSB of `quotient`. After k iterations, the low k bits of `quotient` equal the final quotient shifted right by N-k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request pulse; accepted only when idle |
| dividend | input | 2N-1 | Unsigned dividend, captured on an accepted start |
| divisor | input | N | Divisor with MSB set, captured on an accepted start |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion strobe |
| div_err | output | 1 | Last accepted request had a zero divisor |
| quotient | output | N | Low half of the working register (quotient once done) |
| remainder | output | N | High half of the working register (remainder once done) |

## Verification
For N=4 the bench runs every dividend against every normalised divisor. It checks the partial quotient after each cycle, so a swapped shift direction or an inverted borrow shows up at the first iteration, not only in the final product. An off-by-one in the step counter shows as `done` one cycle early or late. A window that leaves out the MSB of the low half shows as a wrong remainder near remainder = divisor-1. A start that is not blocked while busy would reload the operands in the middle of a run, and the original result would be lost. A zero divisor that is allowed to iterate would keep `busy` high and leave `div_err` low.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_e;
endpackage

// File: rtl/div_hs_cell.sv
`timescale 1ns/1ps
// Half-subtractor with result select: y = sel ? (a-b) : a
module div_hs_cell (
  input  logic a,
  input  logic b,
  input  logic sel,
  output logic y,
  output logic bo
);
  logic diff;
  always_comb begin
    diff = a ^ b;
    bo   = ~a & b;
    y    = sel ? diff : a;
  end
endmodule

// File: rtl/div_fs_cell.sv
`timescale 1ns/1ps
// Full-subtractor with result select: y = sel ? (a-b-bi) : a
module div_fs_cell (
  input  logic a,
  input  logic b,
  input  logic bi,
  input  logic sel,
  output logic y,
  output logic bo
);
  logic diff;
  always_comb begin
    diff = a ^ b ^ bi;
    bo   = (~a & b) | (~(a ^ b) & bi);
    y    = sel ? diff : a;
  end
endmodule

// File: rtl/div_cell_row.sv
`timescale 1ns/1ps
// One iteration: subtract divisor from the (N+1)-bit window, keep difference
// when no borrow leaves the top cell.
module div_cell_row #(
  parameter int N = 4
) (
  input  logic [N:0]   win,
  input  logic [N-1:0] dvs,
  output logic [N:0]   rem_next,
  output logic         qbit
);
  logic [N+1:0] brw;

  assign brw[0] = 1'b0;
  assign qbit   = ~brw[N+1];

  generate
    for (genvar i = 0; i <= N; i++) begin : g_cell
      if (i == 0) begin : g_lo
        div_hs_cell u_c (.a(win[i]), .b(dvs[i]), .sel(qbit),
                         .y(rem_next[i]), .bo(brw[i+1]));
      end else if (i < N) begin : g_mid
        div_fs_cell u_c (.a(win[i]), .b(dvs[i]), .bi(brw[i]), .sel(qbit),
                         .y(rem_next[i]), .bo(brw[i+1]));
      end else begin : g_hi
        div_hs_cell u_c (.a(win[i]), .b(brw[i]), .sel(qbit),
                         .y(rem_next[i]), .bo(brw[i+1]));
      end
    end
  endgenerate
endmodule

// File: rtl/div_step_ctr.sv
`timescale 1ns/1ps
module div_step_ctr #(
  parameter int N  = 4,
  parameter int CW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic last
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clr || en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(N-1));

  // R3: step index never passes N-1 while iterating
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= CW'(N-1)));
endmodule

// File: rtl/seq_divider.sv
`timescale 1ns/1ps
module seq_divider #(
  parameter  int N  = 4,
  localparam int DW = 2*N - 1,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [N-1:0]  divisor,
  output logic          busy,
  output logic          done,
  output logic          div_err,
  output logic [N-1:0]  quotient,
  output logic [N-1:0]  remainder
);
  import div_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rs_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sn, rs_meta} <= 2'b00;
    else        {rst_sn, rs_meta} <= {rs_meta, 1'b1};
  end

  div_state_e    state_q, state_d;
  logic [2*N-1:0] acc_q, acc_d;
  logic [N-1:0]  dsr_q, dsr_d;
  logic          done_q, done_d, err_q, err_d;
  logic          run, accept, last;
  logic [N:0]    row_rem;
  logic          qbit;

  assign run    = (state_q == ST_RUN);
  assign accept = start && (state_q == ST_IDLE);

  div_cell_row #(.N(N)) u_row (
    .win(acc_q[2*N-1:N-1]), .dvs(dsr_q), .rem_next(row_rem), .qbit(qbit));

  div_step_ctr #(.N(N), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_sn), .clr(accept), .en(run), .last(last));

  always_comb begin
    state_d = state_q;
    acc_d   = acc_q;
    dsr_d   = dsr_q;
    err_d   = err_q;
    done_d  = 1'b0;
    if (accept) begin
      acc_d = {1'b0, dividend};
      dsr_d = divisor;
      err_d = (divisor == '0);
      if (divisor == '0) done_d  = 1'b1;
      else               state_d = ST_RUN;
    end else if (run) begin
      acc_d = {row_rem[N-1:0], acc_q[N-2:0], qbit};
      if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (accept) err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      acc_q <= '0;
      dsr_q <= '0;
    end else begin
      if (accept || run) acc_q <= acc_d;
      if (accept)        dsr_q <= dsr_d;
    end
  end

  assign busy      = run;
  assign done      = done_q;
  assign div_err   = err_q;
  assign quotient  = acc_q[N-1:0];
  assign remainder = acc_q[2*N-1:N];

  // R4: completion strobe lasts one cycle
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_sn)
    done_q |=> !done_q);
  // R3: leaving the run state always signals completion without error
  a_r3_fall_done: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(busy) |-> (done_q && !err_q));
  // R5: selected row result never needs the window's extra bit
  a_r5_row_top_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    (run && dsr_q[N-1]) |-> (row_rem[N] == 1'b0));
  // R5: final remainder below divisor
  a_r5_rem_lt_div: assert property (@(posedge clk) disable iff (!rst_sn)
    (done_q && !err_q && dsr_q[N-1]) |-> (remainder < dsr_q));
  // R6: divisor held while a request arrives mid-run
  a_r6_no_reload: assert property (@(posedge clk) disable iff (!rst_sn)
    (run && start) |=> (dsr_q == $past(dsr_q)));
  // R7: zero divisor completes next cycle with error, no iterations
  a_r7_zero_div: assert property (@(posedge clk) disable iff (!rst_sn)
    (accept && divisor == '0) |=> (done_q && err_q && !run));
endmodule

// File: tb/sim_seq_divider.sv
`timescale 1ns/1ps
module sim_seq_divider;
  localparam int N  = 4;
  localparam int DW = 2*N - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] dividend = '0;
  logic [N-1:0]  divisor = '0;
  logic          busy, done, div_err;
  logic [N-1:0]  quotient, remainder;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  seq_divider #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .div_err(div_err),
    .quotient(quotient), .remainder(remainder));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // run one division; optional mid-run start with other operands
  task automatic do_div(input int d_in, input int v_in, input bit poke);
    int q = d_in / v_in;
    int r = d_in % v_in;
    @(negedge clk);
    start = 1'b1; dividend = DW'(d_in); divisor = N'(v_in);
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", int'(busy), 1);
    chk("R8 err cleared", int'(div_err), 0);
    for (int k = 1; k <= N; k++) begin
      if (poke && k == 2) begin
        start = 1'b1; dividend = DW'((d_in + 37) % 128); divisor = N'(9);
      end
      @(negedge clk);
      start = 1'b0;
      chk("R9 partial quotient", int'(quotient) & ((1 << k) - 1), q >> (N - k));
      if (k < N) begin
        chk("R3 busy mid-run", int'(busy), 1);
        chk("R3 no early done", int'(done), 0);
      end else begin
        chk(poke ? "R6 done on time" : "R3 done on time", int'(done), 1);
        chk("R3 busy low", int'(busy), 0);
      end
    end
    chk(poke ? "R6 quotient kept" : "R5 quotient", int'(quotient), q);
    chk(poke ? "R6 remainder kept" : "R5 remainder", int'(remainder), r);
    chk("R5 identity", int'(quotient) * v_in + int'(remainder), d_in);
    @(negedge clk);
    chk("R4 done one cycle", int'(done), 0);
    chk("R6 idle after run", int'(busy), 0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 err after reset", int'(div_err), 0);

    // R5 R9: every dividend against every normalised divisor
    for (int v = (1 << (N-1)); v < (1 << N); v++)
      for (int d = 0; d < (1 << DW); d++)
        do_div(d, v, 1'b0);

    // R6: start pulses while busy are ignored
    do_div(127, 8, 1'b1);
    do_div(100, 13, 1'b1);

    // R7: zero divisor
    @(negedge clk);
    start = 1'b1; dividend = DW'(55); divisor = '0;
    @(negedge clk);
    start = 1'b0;
    chk("R7 done next cycle", int'(done), 1);
    chk("R7 err raised", int'(div_err), 1);
    chk("R7 never busy", int'(busy), 0);
    @(negedge clk);
    chk("R7 done single", int'(done), 0);
    chk("R8 err held", int'(div_err), 1);
    // R8: cleared by next valid request
    do_div(90, 11, 1'b0);
    finish_up();
  end
endmodule